// File: doc/BRIEF.md
# Polled Byte-Wide Device Controller

This block sits on a processor's load/store bus and gives software three byte-wide registers at fixed addresses in high memory. One holds the data byte, one reports progress, and one accepts commands. Software starts an outbound transfer in two steps: it stores a byte into the data register, then stores a send command. For an inbound transfer it stores a fetch command, polls the status register until the ready flag returns, and then loads the byte from the data register.

On the device side the controller has two streams. The outbound stream is a valid/ready pair. The controller raises `tx_valid` with the byte and keeps both the flag and the byte unchanged until the device returns `tx_ready`. The transfer finishes on the first clock edge where both are high. The inbound stream works the other way round. The controller raises `rx_ready` for the whole fetch and does not lower it until the device presents `rx_valid`. The byte on `rx_data` is captured on that edge. The device can report a failed transfer on `dev_fault`, and this input is sampled on the finishing edge.

A software-enabled interrupt line can replace polling. When enabled, it goes high once a transfer finishes. It stays high until software acknowledges it by writing to the status register or by writing any command.

Top module: `pollio_ctrl`

## Requirements
- R1: The data register answers only at the exact address BASE+0, the status register only at BASE+4 and the command register only at BASE+8, with BASE = 0xFFFF0000. A read at any other address returns 0x00, and a write to any other address changes nothing.
- R2: After reset the data register reads 0x00, the status register reads 0x80 and the command register reads 0x00. `tx_valid`, `rx_ready` and `irq` are low.
- R3: Status bit 7 is the ready flag. A command write with value bit 0 set (and bit 1 clear), issued while ready, does the following: it clears ready on the next edge, raises `tx_valid` with the data register's byte, and holds both until the edge where `tx_ready` is high. Ready sets again on that edge.
- R4: A command write with bit 1 set (and bit 0 clear), issued while ready, clears ready and holds `rx_ready` high until an edge with `rx_valid` high. On that edge `rx_data` is stored into the data register and ready sets.
- R5: A write to the data register while a transfer is in progress has no effect. The outbound byte and the stored byte both stay unchanged.
- R6: Status bit 0 is the error flag. On the finishing edge of a transfer it takes the value of `dev_fault`. An accepted transfer command clears it.
- R7: A command write while not ready is rejected. It sets the error flag, and the transfer in progress continues unchanged.
- R8: A command write with both bit 0 and bit 1 set starts no transfer, leaves ready set and sets the error flag.
- R9: Command bit 2 is the interrupt enable. Every command write updates it, and the command register reads it back in bit 2 with all other bits reading zero. A command write with bits 0 and 1 both clear only updates the enable.
- R10: When the enable is set, `irq` rises on the edge after a transfer finishes. When the enable is clear, `irq` stays low. Status bit 1 mirrors `irq`.
- R11: Once high, `irq` stays high until a write to the status register (any value) or any command write. A status write has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 8 | Store data |
| bus_rdata | output | 8 | Load data (combinational, 0 when not decoded) |
| tx_valid | output | 1 | Outbound byte valid |
| tx_ready | input | 1 | Device takes outbound byte |
| tx_data | output | 8 | Outbound byte |
| rx_valid | input | 1 | Device presents inbound byte |
| rx_ready | output | 1 | Controller waiting for inbound byte |
| rx_data | input | 8 | Inbound byte |
| dev_fault | input | 1 | Device reports failure on the finishing edge |
| irq | output | 1 | Interrupt request |

## Verification
The bench stalls the outbound stream for several cycles and then writes a new data byte. A design that let data writes through while busy would change `tx_data` under a valid flag. The bench also writes commands while a fetch is in flight and writes the illegal both-directions value. A design that accepted either would start a second transfer or drop `rx_ready` early. Decode is probed at the unused fourth slot and at addresses that share the low bits but differ in the high half, which catches a decoder that compares only some address bits. The interrupt is checked across accesses that are not acknowledgements (a store to an unused address), across a status write and across a command write, and with the enable clear. This catches a line that pulses instead of holding, or that ignores its enable.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;
  // register slots, spaced by a word, counted from the base
  localparam int NUM_REGS   = 3;
  localparam int REG_STRIDE = 4;
  localparam int SLOT_DATA  = 0;
  localparam int SLOT_STAT  = 1;
  localparam int SLOT_CMD   = 2;

  // status bit positions
  localparam int ST_READY = 7;
  localparam int ST_IRQ   = 1;
  localparam int ST_ERR   = 0;

  // command bit positions
  localparam int CM_SEND  = 0;
  localparam int CM_FETCH = 1;
  localparam int CM_IEN   = 2;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_SEND  = 2'd1,
    XF_FETCH = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/pio_decode.sv
`timescale 1ns/1ps
module pio_decode #(
  parameter int                ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000,
  parameter int                NREG   = pio_pkg::NUM_REGS,
  parameter int                STRIDE = pio_pkg::REG_STRIDE
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit
);
  // full-width compare for each slot
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = BASE + ADDR_W'(g * STRIDE);
    assign hit[g] = sel && (addr == SLOT_ADDR);
  end
endmodule

// File: rtl/pio_xfer.sv
`timescale 1ns/1ps
module pio_xfer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic              cmd_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_q,
  output logic              ready,
  output logic              err_q,
  output logic              done,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              dev_fault
);
  import pio_pkg::*;

  xfer_state_e state_q;
  logic go_send, go_fetch;

  assign go_send  = wdata[CM_SEND];
  assign go_fetch = wdata[CM_FETCH];

  assign ready    = (state_q == XF_IDLE);
  assign tx_valid = (state_q == XF_SEND);
  assign rx_ready = (state_q == XF_FETCH);
  assign tx_data  = data_q;
  assign done     = (tx_valid && tx_ready) || (rx_valid && rx_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= XF_IDLE;
      data_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        XF_IDLE: begin
          if (data_we) data_q <= wdata;
          if (cmd_we) begin
            if (go_send && go_fetch) begin
              err_q <= 1'b1;
            end else if (go_send) begin
              state_q <= XF_SEND;
              err_q   <= 1'b0;
            end else if (go_fetch) begin
              state_q <= XF_FETCH;
              err_q   <= 1'b0;
            end
          end
        end
        XF_SEND: begin
          if (tx_ready) begin
            state_q <= XF_IDLE;
            err_q   <= dev_fault;
          end
        end
        XF_FETCH: begin
          if (rx_valid) begin
            state_q <= XF_IDLE;
            data_q  <= rx_data;
            err_q   <= dev_fault;
          end
        end
        default: state_q <= XF_IDLE;
      endcase
      // a command arriving mid-transfer is refused and flagged
      if (cmd_we && !ready) err_q <= 1'b1;
    end
  end

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !rx_valid |=> rx_ready);
  // R7
  busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && !ready && !done |=> err_q && !ready);
  // R3
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready);
endmodule

// File: rtl/pio_irq.sv
`timescale 1ns/1ps
module pio_irq #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              stat_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  output logic              ien_q,
  output logic              pend_q
);
  import pio_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (cmd_we) ien_q <= wdata[CM_IEN];
      if (done && ien_q)          pend_q <= 1'b1;
      else if (stat_we || cmd_we) pend_q <= 1'b0;
    end
  end

  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !stat_we && !cmd_we |=> pend_q);
  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(done) && $past(ien_q));
endmodule

// File: rtl/pollio_ctrl.sv
`timescale 1ns/1ps
module pollio_ctrl #(
  parameter int                ADDR_W = 32,
  parameter int                DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              dev_fault,
  output logic              irq
);
  import pio_pkg::*;

  logic [NUM_REGS-1:0] hit;
  logic                data_we, stat_we, cmd_we;
  logic [DATA_W-1:0]   data_q;
  logic                ready, err_q, done, ien_q;

  pio_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .sel (bus_sel),
    .addr(bus_addr),
    .hit (hit)
  );

  assign data_we = hit[SLOT_DATA] && bus_we;
  assign stat_we = hit[SLOT_STAT] && bus_we;
  assign cmd_we  = hit[SLOT_CMD]  && bus_we;

  pio_xfer #(.DATA_W(DATA_W)) u_xfer (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_we  (data_we),
    .cmd_we   (cmd_we),
    .wdata    (bus_wdata),
    .data_q   (data_q),
    .ready    (ready),
    .err_q    (err_q),
    .done     (done),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_data  (rx_data),
    .dev_fault(dev_fault)
  );

  pio_irq #(.DATA_W(DATA_W)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_we (cmd_we),
    .stat_we(stat_we),
    .wdata  (bus_wdata),
    .done   (done),
    .ien_q  (ien_q),
    .pend_q (irq)
  );

  // load path; undecoded addresses return zero
  always_comb begin
    bus_rdata = '0;
    if (hit[SLOT_DATA]) begin
      bus_rdata = data_q;
    end else if (hit[SLOT_STAT]) begin
      bus_rdata[ST_READY] = ready;
      bus_rdata[ST_IRQ]   = irq;
      bus_rdata[ST_ERR]   = err_q;
    end else if (hit[SLOT_CMD]) begin
      bus_rdata[CM_IEN] = ien_q;
    end
  end

  // R1
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |-> (bus_rdata == '0));
endmodule

// File: tb/pollio_ctrl_tb_top.sv
`timescale 1ns/1ps
module pollio_ctrl_tb_top;
  localparam logic [31:0] BASE  = 32'hFFFF_0000;
  localparam logic [31:0] A_DAT = BASE + 32'd0;
  localparam logic [31:0] A_STA = BASE + 32'd4;
  localparam logic [31:0] A_CMD = BASE + 32'd8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata, tx_data, rx_data = '0;
  logic tx_valid, tx_ready = 1'b0, rx_valid = 1'b0, rx_ready, dev_fault = 1'b0, irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pollio_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .dev_fault(dev_fault), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic tx_accept(input logic fault);
    @(negedge clk);
    tx_ready = 1'b1; dev_fault = fault;
    @(negedge clk);
    tx_ready = 1'b0; dev_fault = 1'b0;
  endtask

  task automatic rx_give(input logic [7:0] b, input logic fault);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b; dev_fault = fault;
    @(negedge clk);
    rx_valid = 1'b0; dev_fault = 1'b0;
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(A_DAT, v); check("R2 data", v, 8'h00);
    rd(A_STA, v); check("R2 status", v, 8'h80);
    rd(A_CMD, v); check("R2 cmd", v, 8'h00);
    check("R2 lines", {tx_valid, rx_ready, irq}, 3'b000);
  endtask

  task automatic t_decode;
    logic [7:0] v;
    wr(A_DAT, 8'h77);
    rd(A_DAT, v); check("R1 data slot", v, 8'h77);
    rd(BASE + 32'hC, v); check("R1 fourth slot", v, 8'h00);
    rd(32'h0000_0000, v); check("R1 low addr", v, 8'h00);
    rd(32'h7FFF_0004, v); check("R1 alias status", v, 8'h00);
    wr(32'h7FFF_0000, 8'h11);
    rd(A_DAT, v); check("R1 alias write ignored", v, 8'h77);
    wr(32'hFFFF_0018, 8'h01);
    check("R1 alias cmd no send", tx_valid, 1'b0);
    rd(A_STA, v); check("R1 status after alias", v, 8'h80);
  endtask

  task automatic t_send;
    logic [7:0] v;
    wr(A_DAT, 8'hA5);
    wr(A_CMD, 8'h01);
    rd(A_STA, v); check("R3 busy status", v, 8'h00);
    check("R3 tx_valid", tx_valid, 1'b1);
    check("R3 tx_data", tx_data, 8'hA5);
    repeat (3) @(negedge clk);
    check("R3 stall hold", {tx_valid, tx_data}, {1'b1, 8'hA5});
    wr(A_DAT, 8'h3C);
    check("R5 tx byte unchanged", tx_data, 8'hA5);
    tx_accept(1'b0);
    check("R3 tx released", tx_valid, 1'b0);
    rd(A_STA, v); check("R3 ready back", v, 8'h80);
    rd(A_DAT, v); check("R5 data kept", v, 8'hA5);
    check("R10 no irq when disabled", irq, 1'b0);
  endtask

  task automatic t_fetch_busy;
    logic [7:0] v;
    wr(A_CMD, 8'h02);
    check("R4 rx_ready", rx_ready, 1'b1);
    repeat (2) @(negedge clk);
    check("R4 rx_ready held", rx_ready, 1'b1);
    wr(A_CMD, 8'h01);
    rd(A_STA, v); check("R7 reject flags error", v, 8'h01);
    check("R7 fetch continues", {rx_ready, tx_valid}, 2'b10);
    rx_give(8'h5A, 1'b0);
    check("R4 rx_ready dropped", rx_ready, 1'b0);
    rd(A_STA, v); check("R4 ready, R6 no fault", v, 8'h80);
    rd(A_DAT, v); check("R4 byte captured", v, 8'h5A);
  endtask

  task automatic t_fault;
    logic [7:0] v;
    wr(A_CMD, 8'h01);
    tx_accept(1'b1);
    rd(A_STA, v); check("R6 fault flagged", v, 8'h81);
    wr(A_CMD, 8'h02);
    rd(A_STA, v); check("R6 cleared by accept", v, 8'h00);
    rx_give(8'hC3, 1'b0);
  endtask

  task automatic t_bad_cmd;
    logic [7:0] v;
    wr(A_CMD, 8'h03);
    check("R8 no transfer", {tx_valid, rx_ready}, 2'b00);
    rd(A_STA, v); check("R8 ready and error", v, 8'h81);
    wr(A_CMD, 8'h04);
    rd(A_CMD, v); check("R9 enable readback", v, 8'h04);
    rd(A_STA, v); check("R9 enable-only write", v, 8'h81);
    check("R9 no transfer", {tx_valid, rx_ready}, 2'b00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr(A_CMD, 8'h05);
    check("R10 low while busy", irq, 1'b0);
    tx_accept(1'b0);
    check("R10 irq raised", irq, 1'b1);
    rd(A_STA, v); check("R10 status mirror", v, 8'h82);
    repeat (3) @(negedge clk);
    wr(BASE + 32'hC, 8'hFF);
    check("R11 irq held", irq, 1'b1);
    wr(A_STA, 8'h00);
    check("R11 status ack", irq, 1'b0);
    rd(A_STA, v); check("R11 status write benign", v, 8'h80);
    wr(A_CMD, 8'h06);
    rx_give(8'h42, 1'b0);
    check("R10 irq after fetch", irq, 1'b1);
    wr(A_CMD, 8'h00);
    check("R11 cmd ack", irq, 1'b0);
    rd(A_CMD, v); check("R9 enable cleared", v, 8'h00);
    wr(A_CMD, 8'h01);
    tx_accept(1'b0);
    @(negedge clk);
    check("R10 disabled no irq", irq, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_send();
    t_fetch_busy();
    t_fault();
    t_bad_cmd();
    t_irq();
    repeat (2) @(negedge clk);
    summary();
  end
endmodule